// File: doc/BRIEF.md
# DRAM Mode and Read Command Guard

This block sits beside a DRAM controller and watches the decoded command stream it sends to the memory. It tracks which banks are open and counts the clocks since the array was last fully precharged. It also counts the clocks since the delay-locked loop was last switched on. From these three pieces of state it judges two kinds of command in the cycle they appear. A mode register set is legal only when all banks are closed and the precharge recovery time has passed. A read is legal only when the DLL is on and has had its full lock time.

The guard is purely an observer with a verdict. `cmd_allow` falls in the same cycle as an offending command, and one dedicated pulse names the rule that was broken. The controller may use `cmd_allow` to hold the command back, or it may only log the pulses. DLL switching is reported to the guard on its own strobe pair. A self-refresh exit command turns the DLL back on and restarts its lock wait.

Top module: `dram_cmd_guard`

## Requirements
- R1: After reset all banks are closed, the precharge recovery window counts as already elapsed, and the DLL is off. An immediate mode register set is allowed and an immediate read is flagged.
- R2: Command codes on `cmd_code` are: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all, 6 mode register set, 7 refresh, 8 self-refresh entry, 9 self-refresh exit. Activate opens the bank on `cmd_bank`, precharge closes that bank, and precharge-all closes every bank.
- R3: A mode register set while any bank is open raises `viol_mrs_open` for that one cycle, and `cmd_allow` is low in the same cycle.
- R4: A mode register set issued k cycles after a precharge-all, with all banks closed, raises `viol_mrs_trp` when k < TRP_CYCLES and is allowed when k >= TRP_CYCLES.
- R5: A single-bank precharge that closes the last open bank starts the same recovery window as a precharge-all. A precharge that leaves another bank open, or that targets a bank already closed, does not start the window.
- R6: While the DLL is off, every read raises `viol_read_dll`.
- R7: A DLL-enable write (`dll_wr_valid` with `dll_wr_enable`=1) turns the DLL on and restarts the lock wait. A read k cycles later is flagged when k < LOCK_CYCLES and allowed when k >= LOCK_CYCLES. A repeated enable write restarts the wait.
- R8: A self-refresh exit command turns the DLL on and restarts the lock wait, with the same k rule as R7.
- R9: A DLL-disable write (`dll_wr_enable`=0) turns the DLL off from the next cycle. When a DLL write and a self-refresh exit arrive in the same cycle, the DLL write decides the DLL state.
- R10: With `cmd_valid` low, or for any command other than mode register set and read, no violation pulses and `cmd_allow` is high.
- R11: At most one violation output is high in a cycle. When a mode register set finds a bank open, it reports `viol_mrs_open` and not `viol_mrs_trp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_code | input | 4 | Decoded command code (see R2) |
| cmd_bank | input | BANK_W (2) | Bank address of the command |
| dll_wr_valid | input | 1 | A DLL enable/disable write occurs this cycle |
| dll_wr_enable | input | 1 | 1 switches the DLL on, 0 switches it off |
| cmd_allow | output | 1 | Low in a cycle whose command breaks a rule |
| viol_mrs_open | output | 1 | Mode register set issued with a bank open |
| viol_mrs_trp | output | 1 | Mode register set issued inside the recovery window |
| viol_read_dll | output | 1 | Read issued with the DLL off or not yet locked |

## Verification
A stale open bit in the bank tracker shows up at the first mode register set after the bank should have closed, as a false `viol_mrs_open`. A missing open bit shows up as a missing one. A recovery counter that restarts at the wrong moment, or saturates one cycle off, appears only on a mode register set placed exactly TRP_CYCLES−1 or TRP_CYCLES cycles after the closing precharge. For this reason the bench sweeps that distance. The lock counter is probed in the same way, at LOCK_CYCLES−1 and LOCK_CYCLES cycles after an enable write or a self-refresh exit. A wrong DLL-on bit is exposed by the first read after a disable write.

// File: rtl/dram_cmd_guard_pkg.sv
// Shared command encoding and decoded strobe bundle for the command guard.
// Assumes commands arrive already decoded to a 4-bit code.
package dram_cmd_guard_pkg;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_ACT   = 4'd1,
        CMD_READ  = 4'd2,
        CMD_WRITE = 4'd3,
        CMD_PRE   = 4'd4,
        CMD_PREA  = 4'd5,
        CMD_MRS   = 4'd6,
        CMD_REF   = 4'd7,
        CMD_SRE   = 4'd8,
        CMD_SRX   = 4'd9
    } cmd_e;

    typedef struct packed {
        logic act;
        logic pre;
        logic prea;
        logic mrs;
        logic read;
        logic srx;
    } cmd_strobe_t;

    typedef struct packed {
        logic mrs_open;
        logic mrs_trp;
        logic read_dll;
    } viol_t;

endpackage

// File: rtl/cmd_decode.sv
// Turns a valid-qualified command code into one strobe per command of interest.
// Assumes at most one command per cycle; codes outside the table give no strobe.
module cmd_decode
    import dram_cmd_guard_pkg::*;
(
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_code,
    output cmd_strobe_t stb
);

    cmd_e code;

    // Decode the code into strobes, all gated by the valid flag.
    always_comb begin
        code     = cmd_e'(cmd_code);
        stb      = '0;
        stb.act  = cmd_valid && (code == CMD_ACT);
        stb.pre  = cmd_valid && (code == CMD_PRE);
        stb.prea = cmd_valid && (code == CMD_PREA);
        stb.mrs  = cmd_valid && (code == CMD_MRS);
        stb.read = cmd_valid && (code == CMD_READ);
        stb.srx  = cmd_valid && (code == CMD_SRX);
    end

endmodule

// File: rtl/bank_tracker.sv
// Keeps one open/closed bit per bank and flags a precharge that closes the
// last open bank. Assumes strobes are mutually exclusive within a cycle.
module bank_tracker #(
    parameter int unsigned BANK_W = 2,
    localparam int unsigned NB    = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act,
    input  logic              pre,
    input  logic              prea,
    input  logic [BANK_W-1:0] bank,
    output logic [NB-1:0]     open_q,
    output logic              last_close
);

    logic [NB-1:0] sel;

    // One-hot select of the addressed bank.
    always_comb sel = NB'(1) << bank;

    for (genvar i = 0; i < NB; i++) begin : g_bank
        // Per-bank state: activate opens, precharge or precharge-all closes.
        always_ff @(posedge clk) begin
            if (!rst_n)                 open_q[i] <= 1'b0;
            else if (prea)              open_q[i] <= 1'b0;
            else if (act && sel[i])     open_q[i] <= 1'b1;
            else if (pre && sel[i])     open_q[i] <= 1'b0;
        end

        p_act_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (act && sel[i]) |=> open_q[i]);
    end

    // A precharge to an open bank while every other bank is closed.
    always_comb last_close = pre && |(open_q & sel) && ((open_q & ~sel) == '0);

    p_prea_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prea |=> (open_q == '0));

    p_last_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        last_close |=> (open_q == '0));

endmodule

// File: rtl/elapsed_timer.sv
// Saturating cycle counter: restart sets it to one elapsed cycle, and done
// rises once LIMIT cycles have passed. Reset starts it saturated.
// Assumes LIMIT >= 1.
module elapsed_timer #(
    parameter int unsigned LIMIT = 3,
    localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);

    logic [CW-1:0] cnt_q;

    // Count cycles since the last restart, stopping at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= CW'(LIMIT);
        else if (restart)              cnt_q <= CW'(1);
        else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    // Window has elapsed when the counter sits at its ceiling.
    always_comb done = (cnt_q == CW'(LIMIT));

    p_done_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart) |=> done);

    if (LIMIT > 1) begin : g_restart_chk
        p_restart_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            restart |=> !done);
    end

endmodule

// File: rtl/dram_cmd_guard.sv
// Command guard top: judges mode register set and read commands against bank
// state, precharge recovery time and DLL lock time in the cycle they appear.
// Assumes one decoded command per cycle and DLL writes reported separately.
module dram_cmd_guard
    import dram_cmd_guard_pkg::*;
#(
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned TRP_CYCLES  = 3,
    parameter int unsigned LOCK_CYCLES = 200,
    localparam int unsigned NB         = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_code,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              dll_wr_valid,
    input  logic              dll_wr_enable,
    output logic              cmd_allow,
    output logic              viol_mrs_open,
    output logic              viol_mrs_trp,
    output logic              viol_read_dll
);

    cmd_strobe_t   stb;
    logic [NB-1:0] bank_open;
    logic          last_close;
    logic          trp_done;
    logic          lock_done;
    logic          lock_restart;
    logic          dll_on_q;
    logic          dll_ready;
    viol_t         viol;

    cmd_decode i_decode (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .stb       (stb)
    );

    bank_tracker #(.BANK_W(BANK_W)) i_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .act        (stb.act),
        .pre        (stb.pre),
        .prea       (stb.prea),
        .bank       (cmd_bank),
        .open_q     (bank_open),
        .last_close (last_close)
    );

    elapsed_timer #(.LIMIT(TRP_CYCLES)) i_trp_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (stb.prea || last_close),
        .done    (trp_done)
    );

    // Lock wait restarts on an enable write, or on self-refresh exit without a DLL write.
    always_comb lock_restart = (dll_wr_valid && dll_wr_enable) || (!dll_wr_valid && stb.srx);

    elapsed_timer #(.LIMIT(LOCK_CYCLES)) i_lock_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (lock_restart),
        .done    (lock_done)
    );

    // DLL on/off state: a DLL write wins, otherwise self-refresh exit turns it on.
    always_ff @(posedge clk) begin
        if (!rst_n)            dll_on_q <= 1'b0;
        else if (dll_wr_valid) dll_on_q <= dll_wr_enable;
        else if (stb.srx)      dll_on_q <= 1'b1;
    end

    // Reads are safe only once the DLL is on and its lock wait has run out.
    always_comb dll_ready = dll_on_q && lock_done;

    // Rule checks; an open bank takes precedence over the recovery window.
    always_comb begin
        viol.mrs_open = stb.mrs && |bank_open;
        viol.mrs_trp  = stb.mrs && !(|bank_open) && !trp_done;
        viol.read_dll = stb.read && !dll_ready;
    end

    // Drive the verdict ports.
    always_comb begin
        viol_mrs_open = viol.mrs_open;
        viol_mrs_trp  = viol.mrs_trp;
        viol_read_dll = viol.read_dll;
        cmd_allow     = !(viol.mrs_open || viol.mrs_trp || viol.read_dll);
    end

    p_one_viol_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({viol_mrs_open, viol_mrs_trp, viol_read_dll}));

    p_viol_drops_allow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_mrs_open || viol_mrs_trp || viol_read_dll) |-> !cmd_allow);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> (cmd_allow && !viol_mrs_open && !viol_mrs_trp && !viol_read_dll));

    p_disable_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_wr_valid && !dll_wr_enable) |=> !dll_ready);

    p_srx_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stb.srx && !dll_wr_valid) |=> dll_on_q);

endmodule

// File: tb/test_dram_cmd_guard.sv
`timescale 1ns/1ps
module test_dram_cmd_guard;

    localparam int TRP  = 3;
    localparam int LOCK = 200;
    localparam int BIG  = 1000000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'd0;
    logic [1:0] cmd_bank = 2'd0;
    logic       dll_wr_valid = 1'b0;
    logic       dll_wr_enable = 1'b0;
    logic       cmd_allow, viol_mrs_open, viol_mrs_trp, viol_read_dll;

    int checks = 0;
    int errors = 0;
    logic finished = 1'b0;
    logic [3:0] got;

    // Reference state built from the requirements
    logic [3:0] m_open;
    int         m_trp;
    logic       m_dll_on;
    int         m_lock;

    always #2.5 clk = ~clk;

    dram_cmd_guard #(.BANK_W(2), .TRP_CYCLES(TRP), .LOCK_CYCLES(LOCK)) i_dram_cmd_guard (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_bank(cmd_bank), .dll_wr_valid(dll_wr_valid), .dll_wr_enable(dll_wr_enable),
        .cmd_allow(cmd_allow), .viol_mrs_open(viol_mrs_open),
        .viol_mrs_trp(viol_mrs_trp), .viol_read_dll(viol_read_dll)
    );

    // Expected {allow, mrs_open, mrs_trp, read_dll} for a command in the current state
    function automatic logic [3:0] expect_out(input logic v, input logic [3:0] c);
        if (!v) return 4'b1000;
        if (c == 4'd6) begin
            if (m_open != 4'b0) return 4'b0100;
            if (m_trp < TRP)    return 4'b0010;
            return 4'b1000;
        end
        if (c == 4'd2) begin
            if (!(m_dll_on && m_lock >= LOCK)) return 4'b0001;
            return 4'b1000;
        end
        return 4'b1000;
    endfunction

    task automatic model_reset();
        m_open = 4'b0; m_trp = BIG; m_dll_on = 1'b0; m_lock = BIG;
    endtask

    // Advance the reference state by one clock with the given inputs
    task automatic model_update(input logic v, input logic [3:0] c, input logic [1:0] b,
                                input logic wv, input logic we);
        logic [3:0] sel;
        logic lastc;
        sel = 4'b1 << b;
        lastc = v && c == 4'd4 && (m_open & sel) != 0 && (m_open & ~sel) == 0;
        if (v && c == 4'd5)      m_open = 4'b0;
        else if (v && c == 4'd1) m_open = m_open | sel;
        else if (v && c == 4'd4) m_open = m_open & ~sel;
        if ((v && c == 4'd5) || lastc) m_trp = 1;
        else if (m_trp < BIG) m_trp++;
        if ((wv && we) || (!wv && v && c == 4'd9)) m_lock = 1;
        else if (m_lock < BIG) m_lock++;
        if (wv) m_dll_on = we;
        else if (v && c == 4'd9) m_dll_on = 1'b1;
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b (allow,mrs_open,mrs_trp,read_dll) at %0t",
                     tag, act, exp, $time);
        end
    endtask

    // Drive one cycle, check against the reference, then advance the reference
    task automatic step(input logic v, input logic [3:0] c, input logic [1:0] b,
                        input logic wv, input logic we, input string tag);
        @(negedge clk);
        cmd_valid = v; cmd_code = c; cmd_bank = b; dll_wr_valid = wv; dll_wr_enable = we;
        #1;
        got = {cmd_allow, viol_mrs_open, viol_mrs_trp, viol_read_dll};
        check(tag, got, expect_out(v, c));
        @(posedge clk);
        model_update(v, c, b, wv, we);
    endtask

    task automatic cmd(input logic [3:0] c, input logic [1:0] b, input string tag);
        step(1'b1, c, b, 1'b0, 1'b0, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R10 watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        step(1'b0, 4'd0, 2'd0, 1'b0, 1'b0, "R1");
        check("R1", got, 4'b1000);
        cmd(4'd6, 2'd0, "R1");
        check("R1", got, 4'b1000);
        // R6: read with DLL off
        cmd(4'd2, 2'd0, "R6");
        check("R6", got, 4'b0001);
        // R2 / R3: activate then mode register set
        cmd(4'd1, 2'd2, "R2");
        cmd(4'd6, 2'd0, "R3");
        check("R3", got, 4'b0100);
        // R10: other commands never violate; invalid MRS ignored
        cmd(4'd3, 2'd1, "R10");
        check("R10", got, 4'b1000);
        step(1'b0, 4'd6, 2'd0, 1'b0, 1'b0, "R10");
        check("R10", got, 4'b1000);
        // R11: open bank takes precedence inside recovery window
        cmd(4'd5, 2'd0, "R2");
        cmd(4'd1, 2'd1, "R2");
        cmd(4'd6, 2'd0, "R11");
        check("R11", got, 4'b0100);
        // R4: sweep distance from precharge-all to MRS
        for (int k = 1; k <= TRP + 1; k++) begin
            cmd(4'd5, 2'd0, "R4");
            idle(k - 1);
            cmd(4'd6, 2'd0, "R4");
            check("R4", got, (k < TRP) ? 4'b0010 : 4'b1000);
        end
        // R5: single-bank precharge behaviour
        cmd(4'd1, 2'd0, "R5");
        cmd(4'd1, 2'd3, "R5");
        idle(TRP + 2);
        cmd(4'd4, 2'd0, "R5");
        idle(TRP);
        cmd(4'd6, 2'd0, "R5");
        check("R5", got, 4'b0100);
        cmd(4'd4, 2'd3, "R5");
        cmd(4'd6, 2'd0, "R5");
        check("R5", got, 4'b0010);
        idle(TRP);
        cmd(4'd4, 2'd3, "R5");
        cmd(4'd6, 2'd0, "R5");
        check("R5", got, 4'b1000);
        // R7: lock wait after enable write
        step(1'b0, 4'd0, 2'd0, 1'b1, 1'b1, "R7");
        idle(LOCK - 2);
        cmd(4'd2, 2'd0, "R7");
        check("R7", got, 4'b0001);
        cmd(4'd2, 2'd0, "R7");
        check("R7", got, 4'b1000);
        step(1'b0, 4'd0, 2'd0, 1'b1, 1'b1, "R7");
        idle(4);
        cmd(4'd2, 2'd0, "R7");
        check("R7", got, 4'b0001);
        // R8: self-refresh exit restarts the wait
        idle(LOCK);
        cmd(4'd8, 2'd0, "R8");
        cmd(4'd9, 2'd0, "R8");
        cmd(4'd2, 2'd0, "R8");
        check("R8", got, 4'b0001);
        idle(LOCK - 2);
        cmd(4'd2, 2'd0, "R8");
        check("R8", got, 4'b1000);
        // R9: disable write and priority over self-refresh exit
        step(1'b0, 4'd0, 2'd0, 1'b1, 1'b0, "R9");
        cmd(4'd2, 2'd0, "R9");
        check("R9", got, 4'b0001);
        step(1'b1, 4'd9, 2'd0, 1'b1, 1'b0, "R9");
        idle(LOCK + 10);
        cmd(4'd2, 2'd0, "R9");
        check("R9", got, 4'b0001);
        step(1'b1, 4'd9, 2'd0, 1'b0, 1'b0, "R8");
        idle(LOCK);
        cmd(4'd2, 2'd0, "R8");
        check("R8", got, 4'b1000);

        // Random traffic, checked against the reference every cycle (R2-R11)
        for (int n = 0; n < 20000; n++) begin
            logic [3:0] c;
            logic       v, wv, we;
            int         r;
            r = $urandom_range(0, 99);
            if (r < 20)      c = 4'd6;
            else if (r < 40) c = 4'd2;
            else if (r < 52) c = 4'd1;
            else if (r < 64) c = 4'd4;
            else if (r < 68) c = 4'd5;
            else if (r < 69) c = 4'd9;
            else             c = 4'($urandom_range(0, 9));
            v  = ($urandom_range(0, 9) != 0);
            wv = ($urandom_range(0, 299) == 0);
            we = ($urandom_range(0, 3) != 0);
            step(v, c, 2'($urandom_range(0, 3)), wv, we, "R11");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule